// File: doc/BRIEF.md
# Converter Power and Reference Sequencer

This block decides which parts of a self-powering sampling converter are awake. It receives single-cycle events from the serial bus front end: a matching address byte and its direction bit, the falling clock edge that closes the acknowledge slot of that byte, end of conversion, and a not-acknowledge from the master during readout. A static strap tells it whether the converter runs from its on-chip reference or from an external one. From these it drives registered enables for the converter core, the on-chip reference and the reference buffer, and a flag telling downstream logic that conversion results may be trusted.

The core sleeps unless a conversion is being serviced. The on-chip reference takes much longer to settle, so it may stay up between conversions. The direction bit of the address byte selects the policy. With the bit set, the reference stays on. With the bit clear, a shutdown is armed, and it takes effect only when the master closes the readout with a not-acknowledge. While the reference settles, a counter of slow `ref_tick` pulses holds the ready flag low. Conversions made during that time, including the dummy first conversion, are to be discarded.

Top module: `adc_pwr_seq`

## Requirements
- R1: During reset and on the first cycle after it, `core_en`, `ref_en`, `buf_en` and `ref_ready` are all 0.
- R2: `core_en` is 1 on the cycle after an `addr_hit` pulse, whatever the power state and reference mode.
- R3: `core_en` returns to 0 on the cycle after a `conv_done` pulse. If `addr_hit` and `conv_done` arrive together, `core_en` is 1.
- R4: In internal mode (`ext_ref_sel`=0), an `ack_fall` pulse that follows an `addr_hit` while the reference is off sets `ref_en` on the next cycle. `buf_en` follows exactly one cycle later.
- R5: After the reference powers up, `ref_ready` stays 0 until SETTLE_TICKS `ref_tick` pulses have been counted. It is 1 within two cycles of the last of those pulses.
- R6: An address match and an `ack_fall` that arrive while the reference is settling do not restart the settle count.
- R7: After an address byte whose direction bit (`addr_rw`) is 1, a `mst_nack` leaves `ref_en`, `buf_en` and `ref_ready` unchanged.
- R8: After an address byte whose direction bit is 0, the reference stays on through `conv_done`. The next `mst_nack` clears `ref_en`, `buf_en` and `ref_ready` on the following cycle.
- R9: A later address byte with direction bit 1 cancels an armed shutdown.
- R10: In external mode (`ext_ref_sel`=1), `ref_en` and `buf_en` stay 0 whatever the direction bit and bus events are. `ref_ready` is 1 from the second cycle after reset is released.
- R11: An `ack_fall` pulse with no `addr_hit` since the previous `ack_fall` does not power the reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset (power-on) |
| ext_ref_sel | input | 1 | Static strap: 1 selects the external reference |
| addr_hit | input | 1 | Pulse: address byte matched this device |
| addr_rw | input | 1 | Direction bit of the matched byte, valid with `addr_hit` |
| ack_fall | input | 1 | Pulse: falling clock edge that ends the address acknowledge |
| conv_done | input | 1 | Pulse: conversion finished |
| mst_nack | input | 1 | Pulse: master not-acknowledge during readout |
| ref_tick | input | 1 | Slow time-base pulse for the settle count |
| core_en | output | 1 | Converter core enable |
| ref_en | output | 1 | On-chip reference enable |
| buf_en | output | 1 | Reference buffer enable |
| ref_ready | output | 1 | Reference settled; results valid |

## Verification
The bench stops the settle count one tick short to catch an off-by-one timer, which would raise the ready flag early and let dummy results through. It wakes the block during settling: a design that restarts the timer would keep the flag low for longer than the required count. It sends a not-acknowledge after each direction-bit setting, which exposes a design that drops the reference on `conv_done`, or one that ignores a later direction bit of 1. Bare acknowledge edges, simultaneous wake and done, and a reset into external mode cover the remaining cases: a spurious power-up, a lost wake, or a reference enabled against the strap.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;

  // One step of the settle countdown: decrement on a tick, floor at zero.
  function automatic logic [31:0] settle_step(logic [31:0] left, logic tick);
    return (tick && (left != 32'd0)) ? left - 32'd1 : left;
  endfunction

  // Counter width needed to hold a tick count.
  function automatic int unsigned cnt_width(int unsigned ticks);
    return $clog2(ticks + 1);
  endfunction

endpackage

// File: rtl/adc_settle_timer.sv
module adc_settle_timer
  import adc_pwr_pkg::*;
#(
  parameter int unsigned TICKS = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  input  logic tick,
  output logic busy
);
  localparam int unsigned CW = cnt_width(TICKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (abort)  cnt_q <= '0;
    else if (start)  cnt_q <= CW'(TICKS);
    else             cnt_q <= CW'(settle_step(32'(cnt_q), tick));
  end

  assign busy = (cnt_q != '0);

  // R6: once running, the count never climbs back (no restart).
  a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !abort) |=> (cnt_q <= $past(cnt_q)));

  // R5: counting only starts from a start request.
  a_r5_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

endmodule

// File: rtl/adc_core_ctl.sv
module adc_core_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic done,
  output logic core_en
);
  logic core_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    core_q <= 1'b0;
    else if (hit)  core_q <= 1'b1;
    else if (done) core_q <= 1'b0;
  end

  assign core_en = core_q;

  // R2: an address match wakes the core on the next cycle.
  a_r2_wake_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> core_en);

  // R3: the core only sleeps after a conversion completes.
  a_r3_sleep_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_en) |-> $past(done));

endmodule

// File: rtl/adc_ref_ctl.sv
module adc_ref_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_ref,
  input  logic hit,
  input  logic rw,
  input  logic ninth,
  input  logic nack,
  output logic ref_en,
  output logic buf_en,
  output logic start,
  output logic stop
);
  logic pend_q, armed_q, ref_q, buf_q;

  // Internal events, named for the assertions and the timer.
  assign start = ninth && pend_q && !ref_q && !ext_ref;
  assign stop  = nack && armed_q && ref_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      armed_q <= 1'b0;
      ref_q   <= 1'b0;
      buf_q   <= 1'b0;
    end else begin
      if (hit)        pend_q <= 1'b1;
      else if (ninth) pend_q <= 1'b0;

      if (hit)       armed_q <= !ext_ref && !rw;
      else if (nack) armed_q <= 1'b0;

      if (stop)       ref_q <= 1'b0;
      else if (start) ref_q <= 1'b1;

      buf_q <= ref_q && !stop;
    end
  end

  assign ref_en = ref_q;
  assign buf_en = buf_q;

  // R4: the buffer comes up only after the reference.
  a_r4_buf_after_ref: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_en) |-> $past(ref_en));

  // R4: the buffer is never on without the reference.
  a_r4_buf_needs_ref: assert property (@(posedge clk) disable iff (!rst_n)
    buf_en |-> ref_en);

  // R8: the reference only drops on a master not-acknowledge with shutdown armed.
  a_r8_off_on_nack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ref_en) |-> $past(nack && armed_q));

  // R10: external mode never powers the on-chip reference.
  a_r10_ext_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ref |-> (!ref_en && !buf_en));

  // R11: an acknowledge edge without a pending wake changes nothing.
  a_r11_stray_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (ninth && !pend_q && !nack) |=> (ref_en == $past(ref_en)));

endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq #(
  parameter int unsigned SETTLE_TICKS = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_ref_sel,
  input  logic addr_hit,
  input  logic addr_rw,
  input  logic ack_fall,
  input  logic conv_done,
  input  logic mst_nack,
  input  logic ref_tick,
  output logic core_en,
  output logic ref_en,
  output logic buf_en,
  output logic ref_ready
);
  logic settle_start, ref_stop, settling, rdy_q;

  adc_core_ctl u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (addr_hit),
    .done    (conv_done),
    .core_en (core_en)
  );

  adc_ref_ctl u_ref (
    .clk     (clk),
    .rst_n   (rst_n),
    .ext_ref (ext_ref_sel),
    .hit     (addr_hit),
    .rw      (addr_rw),
    .ninth   (ack_fall),
    .nack    (mst_nack),
    .ref_en  (ref_en),
    .buf_en  (buf_en),
    .start   (settle_start),
    .stop    (ref_stop)
  );

  adc_settle_timer #(.TICKS(SETTLE_TICKS)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (settle_start),
    .abort (ref_stop),
    .tick  (ref_tick),
    .busy  (settling)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= ext_ref_sel || (ref_en && !settling && !ref_stop);
  end

  assign ref_ready = rdy_q;

  // R5: in internal mode, ready implies a powered reference.
  a_r5_ready_needs_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_ready && !ext_ref_sel) |-> ref_en);

  // R5: ready never rises while the settle count is still running.
  a_r5_no_early_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (settling && !ext_ref_sel) |=> !ref_ready);

endmodule

// File: tb/adc_pwr_seq_bench.sv
module adc_pwr_seq_bench;
  localparam int unsigned N = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_ref_sel = 1'b0;
  logic addr_hit = 1'b0, addr_rw = 1'b0, ack_fall = 1'b0;
  logic conv_done = 1'b0, mst_nack = 1'b0, ref_tick = 1'b0;
  logic core_en, ref_en, buf_en, ref_ready;

  int n_chk = 0;
  int n_bad = 0;

  // Bench model state
  bit m_core, m_on, m_pend, m_armed, m_ext;
  int m_left;

  always #10 clk = ~clk;

  adc_pwr_seq #(.SETTLE_TICKS(N)) u_adc_pwr_seq (
    .clk(clk), .rst_n(rst_n), .ext_ref_sel(ext_ref_sel),
    .addr_hit(addr_hit), .addr_rw(addr_rw), .ack_fall(ack_fall),
    .conv_done(conv_done), .mst_nack(mst_nack), .ref_tick(ref_tick),
    .core_en(core_en), .ref_en(ref_en), .buf_en(buf_en), .ref_ready(ref_ready)
  );

  function automatic bit exp_ready();
    return m_ext || (m_on && m_left == 0);
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One-cycle stimulus; the model follows the requirements.
  task automatic drive(bit h, bit rw, bit nf, bit dn, bit nk, bit tk);
    bit st, sp;
    @(negedge clk);
    addr_hit = h; addr_rw = rw; ack_fall = nf; conv_done = dn; mst_nack = nk; ref_tick = tk;
    st = nf && m_pend && !m_on && !m_ext;
    sp = nk && m_armed && m_on;
    m_core = h ? 1'b1 : (dn ? 1'b0 : m_core);
    if (sp) begin m_on = 0; m_left = 0; end
    else if (st) begin m_on = 1; m_left = N; end
    else if (tk && m_left > 0) m_left--;
    if (h) m_pend = 1; else if (nf) m_pend = 0;
    if (h) m_armed = !m_ext && !rw; else if (nk) m_armed = 0;
    @(negedge clk);
    addr_hit = 0; addr_rw = 0; ack_fall = 0; conv_done = 0; mst_nack = 0; ref_tick = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_all(string tag);
    idle(3);
    check({tag, " core_en"}, core_en, m_core);
    check({tag, " ref_en"}, ref_en, m_on);
    check({tag, " buf_en"}, buf_en, m_on);
    check({tag, " ref_ready"}, ref_ready, exp_ready());
  endtask

  task automatic do_reset(bit ext);
    rst_n = 0; ext_ref_sel = ext;
    m_core = 0; m_on = 0; m_pend = 0; m_armed = 0; m_left = 0; m_ext = ext;
    idle(3);
    check("R1 core_en in reset", core_en, 0);
    check("R1 ref_en in reset", ref_en, 0);
    check("R1 buf_en in reset", buf_en, 0);
    check("R1 ref_ready in reset", ref_ready, 0);
    rst_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // ---------------- internal reference mode ----------------
    do_reset(1'b0);
    @(negedge clk);
    check("R1 core_en after reset", core_en, 0);
    check("R1 ref_ready after reset", ref_ready, 0);

    // R11: stray acknowledge edge
    drive(0, 0, 1, 0, 0, 0);
    expect_all("R11 stray ack_fall");
    check("R11 ref_en stays off", ref_en, 0);

    // R2 / R4 wake and power-up order
    drive(1, 1, 0, 0, 0, 0);
    check("R2 core_en next cycle", core_en, 1);
    drive(0, 0, 1, 0, 0, 0);
    check("R4 ref_en next cycle", ref_en, 1);
    check("R4 buf_en lags", buf_en, 0);
    @(negedge clk);
    check("R4 buf_en one cycle later", buf_en, 1);

    // R5 one tick short, R6 wake during settling
    for (int i = 0; i < int'(N) - 1; i++) drive(0, 0, 0, 0, 0, 1);
    expect_all("R5 one tick short");
    check("R5 ready low before last tick", ref_ready, 0);
    drive(1, 1, 0, 0, 0, 0);
    drive(0, 0, 1, 0, 0, 0);
    expect_all("R6 wake while settling");
    drive(0, 0, 0, 0, 0, 1);
    idle(2);
    check("R6 ready after original count", ref_ready, 1);
    expect_all("R5 settled");

    // R3 / R7
    drive(0, 0, 0, 1, 0, 0);
    check("R3 core_en off after done", core_en, 0);
    drive(0, 0, 0, 0, 1, 0);
    expect_all("R7 nack with rw=1");
    check("R7 ref_en kept", ref_en, 1);
    drive(1, 1, 0, 1, 0, 0);
    check("R3 simultaneous hit and done", core_en, 1);
    drive(0, 0, 1, 0, 0, 0);

    // R8 armed shutdown
    drive(1, 0, 0, 0, 0, 0);
    drive(0, 0, 1, 0, 0, 0);
    drive(0, 0, 0, 1, 0, 0);
    expect_all("R8 done before nack");
    check("R8 ref_en kept through done", ref_en, 1);
    drive(0, 0, 0, 0, 1, 0);
    check("R8 ref_en off after nack", ref_en, 0);
    check("R8 buf_en off after nack", buf_en, 0);
    check("R8 ready off after nack", ref_ready, 0);

    // R9 disarm
    drive(1, 0, 0, 0, 0, 0);
    drive(0, 0, 1, 0, 0, 0);
    for (int i = 0; i < int'(N); i++) drive(0, 0, 0, 0, 0, 1);
    drive(1, 1, 0, 0, 0, 0);
    drive(0, 0, 1, 0, 0, 0);
    drive(0, 0, 0, 0, 1, 0);
    expect_all("R9 disarmed");
    check("R9 ref_en kept", ref_en, 1);

    // Random traffic against the model
    for (int k = 0; k < 500; k++) begin
      int op;
      op = $urandom_range(0, 7);
      case (op)
        0: drive(1, 1'($urandom_range(0, 1)), 0, 0, 0, 0);
        1: drive(0, 0, 1, 0, 0, 0);
        2: drive(0, 0, 0, 1, 0, 0);
        3: drive(0, 0, 0, 0, 1, 0);
        default: drive(0, 0, 0, 0, 0, 1);
      endcase
      if (k % 5 == 4) expect_all("R8 random");
    end

    // ---------------- external reference mode ----------------
    do_reset(1'b1);
    idle(2);
    check("R10 ready high in ext mode", ref_ready, 1);
    drive(1, 0, 0, 0, 0, 0);
    drive(0, 0, 1, 0, 0, 0);
    expect_all("R10 ext wake rw=0");
    drive(0, 0, 0, 0, 1, 0);
    expect_all("R10 ext nack");
    drive(1, 1, 0, 0, 0, 0);
    drive(0, 0, 1, 0, 0, 0);
    expect_all("R10 ext wake rw=1");
    check("R10 ref_en stays off", ref_en, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule